// File: doc/BRIEF.md
# Decimal Digit Step Unit

This block takes one decimal digit, carried on four bits, and returns the next digit in counting order. Counting runs 0 through 9 and then starts again at 0. The block has no clock and no stored state. Its outputs follow its input directly, so it can sit on any datapath that has to advance a decimal digit.

Six of the sixteen four-bit codes carry no decimal value. The block does not leave these undefined. Every one of them produces 0000, so no illegal code ever reaches the output. Two flags travel with the result:

- The wrap flag marks the single step from nine back to zero. A neighbouring digit can use it as a carry-in.
- The invalid flag marks an input that was out of range. Downstream logic can then tell a real rollover apart from a forced zero.

The digit width and the radix are parameters. The defaults are 4 bits and radix 10.

Top module: `bcd_digit_inc`

## Requirements
- R1: For input codes 0000 through 1000 (values 0 to 8), `digit_o` equals the input plus one in plain binary, and both flags are low.
- R2: Input 1001 (nine) gives `digit_o` = 0000.
- R3: Each of the input codes 1010, 1011, 1100, 1101, 1110 and 1111 gives `digit_o` = 0000.
- R4: `wrap_o` is 1 when the input is 1001 and 0 for every other code, including the six unused ones.
- R5: `invalid_o` is 1 exactly when the input is 1010 or above, and 0 for codes 0000 to 1001.
- R6: `digit_o` is always a legal decimal code, that is 1001 or below.
- R7: The outputs depend only on the present input. A change on `digit_i` shows up on the outputs without any clock edge.
- R8: `wrap_o` and `invalid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit_i | input | 4 | Decimal digit to advance; codes above 1001 are accepted and flagged |
| digit_o | output | 4 | Next decimal digit; 0000 after nine and for any illegal input |
| wrap_o | output | 1 | High only when the input was nine and the result rolled over |
| invalid_o | output | 1 | High when the input code was outside the decimal range |

## Verification
The bench looks hardest at three boundaries:

- **The eight-to-nine step.** A design that wrapped one code too early would turn 1000 into 0000 instead of 1001.
- **The nine-to-zero step.** A design that forgot the wrap would emit the illegal code 1010.
- **The six unused codes.** A plain binary incrementer would pass 1011 through 1111 on, and 1111 would come back as 0000 with no invalid flag. A design that reused the wrap logic would raise wrap on these codes and so signal a false carry.

Every code is applied in three different orders, so a design that depended on the previous value would fail at least one of them. The input is also changed between clock edges, to expose any hidden register stage.

// File: rtl/bcdinc_pkg.sv
package bcdinc_pkg;

  // Classification of an incoming digit code.
  typedef enum logic [1:0] {
    DC_RUN = 2'd0,  // legal digit below the top value
    DC_TOP = 2'd1,  // highest legal digit, next step rolls over
    DC_BAD = 2'd2   // code outside the decimal range
  } dclass_e;

endpackage

// File: rtl/bcdinc_classify.sv
module bcdinc_classify #(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic [DIGIT_W-1:0]  digit_i,
  output bcdinc_pkg::dclass_e class_o
);
  import bcdinc_pkg::*;

  localparam logic [DIGIT_W-1:0] TOP_CODE = DIGIT_W'(RADIX - 1);

  always_comb begin
    if (digit_i > TOP_CODE) begin
      class_o = DC_BAD;
    end else if (digit_i == TOP_CODE) begin
      class_o = DC_TOP;
    end else begin
      class_o = DC_RUN;
    end
  end

endmodule

// File: rtl/bcdinc_adder.sv
module bcdinc_adder #(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [DIGIT_W-1:0] sum_o
);

  // Ripple increment written out per bit: a bit flips when all lower bits are 1.
  logic [DIGIT_W:0] carry;

  assign carry[0] = 1'b1;

  for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
    assign sum_o[b]   = digit_i[b] ^ carry[b];
    assign carry[b+1] = digit_i[b] & carry[b];
  end

endmodule

// File: rtl/bcdinc_select.sv
module bcdinc_select #(
  parameter int DIGIT_W = 4
) (
  input  bcdinc_pkg::dclass_e class_i,
  input  logic [DIGIT_W-1:0]  sum_i,
  output logic [DIGIT_W-1:0]  digit_o,
  output logic                wrap_o,
  output logic                invalid_o
);
  import bcdinc_pkg::*;

  always_comb begin
    digit_o   = '0;
    wrap_o    = 1'b0;
    invalid_o = 1'b0;
    unique case (class_i)
      DC_RUN: digit_o = sum_i;
      DC_TOP: wrap_o = 1'b1;
      DC_BAD: invalid_o = 1'b1;
      default: begin
        digit_o   = '0;
        wrap_o    = 1'b0;
        invalid_o = 1'b0;
      end
    endcase
  end

  // Only the rollover and illegal classes may force a zero result.
  always_comb begin
    if (!$isunknown(class_i)) begin
      p_flag_forces_zero_r3: assert (!(wrap_o || invalid_o) || digit_o == '0)
        else $error("flagged result is not zero");
    end
  end

endmodule

// File: rtl/bcd_digit_inc.sv
module bcd_digit_inc #(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               wrap_o,
  output logic               invalid_o
);
  import bcdinc_pkg::*;

  localparam logic [DIGIT_W-1:0] TOP_CODE = DIGIT_W'(RADIX - 1);

  dclass_e            dclass;
  logic [DIGIT_W-1:0] plus_one;

  bcdinc_classify #(
    .DIGIT_W(DIGIT_W),
    .RADIX  (RADIX)
  ) u_classify (
    .digit_i(digit_i),
    .class_o(dclass)
  );

  bcdinc_adder #(
    .DIGIT_W(DIGIT_W)
  ) u_adder (
    .digit_i(digit_i),
    .sum_o  (plus_one)
  );

  bcdinc_select #(
    .DIGIT_W(DIGIT_W)
  ) u_select (
    .class_i  (dclass),
    .sum_i    (plus_one),
    .digit_o  (digit_o),
    .wrap_o   (wrap_o),
    .invalid_o(invalid_o)
  );

  // Port-level checks on the combined result.
  always_comb begin
    if (!$isunknown(digit_i)) begin
      p_out_legal_r6: assert (digit_o <= TOP_CODE)
        else $error("output code above top digit");
      p_flags_excl_r8: assert (!(wrap_o && invalid_o))
        else $error("wrap and invalid both high");
      p_wrap_at_top_r4: assert (wrap_o == (digit_i == TOP_CODE))
        else $error("wrap flag mismatch");
      p_bad_flag_r5: assert (invalid_o == (digit_i > TOP_CODE))
        else $error("invalid flag mismatch");
      p_step_value_r1: assert (digit_i >= TOP_CODE || digit_o == digit_i + DIGIT_W'(1))
        else $error("legal step result wrong");
      p_nine_to_zero_r2: assert (digit_i != TOP_CODE || digit_o == '0)
        else $error("top digit did not roll to zero");
    end
  end

endmodule

// File: tb/bcd_digit_inc_bench.sv
module bcd_digit_inc_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] din;
    logic [3:0] y;
    logic       wrap;
    logic       bad;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [3:0] digit_i;
  logic [3:0] digit_o;
  logic       wrap_o;
  logic       invalid_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  item_t sb_q[$];

  bcd_digit_inc u_bcd_digit_inc (
    .digit_i  (digit_i),
    .digit_o  (digit_o),
    .wrap_o   (wrap_o),
    .invalid_o(invalid_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected result per code, written from the requirements as a literal table.
  function automatic item_t expect_of(input logic [3:0] d);
    item_t e;
    e.din  = d;
    e.wrap = 1'b0;
    e.bad  = 1'b0;
    case (d)
      4'd0: e.y = 4'd1;
      4'd1: e.y = 4'd2;
      4'd2: e.y = 4'd3;
      4'd3: e.y = 4'd4;
      4'd4: e.y = 4'd5;
      4'd5: e.y = 4'd6;
      4'd6: e.y = 4'd7;
      4'd7: e.y = 4'd8;
      4'd8: e.y = 4'd9;
      4'd9: begin e.y = 4'd0; e.wrap = 1'b1; end
      default: begin e.y = 4'd0; e.bad = 1'b1; end
    endcase
    return e;
  endfunction

  function automatic string tag_of(input logic [3:0] d);
    if (d <= 4'd8) return "R1";
    if (d == 4'd9) return "R2";
    return "R3";
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp,
                       input logic [3:0] din);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s din=%b actual=%b expected=%b", req, din, act, exp);
    end
  endtask

  // Driver: applies a code just after the active edge and queues its expectation.
  task automatic drive(input logic [3:0] d);
    @(posedge clk);
    #1;
    digit_i = d;
    sb_q.push_back(expect_of(d));
  endtask

  // Monitor: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      check(tag_of(e.din), digit_o, e.y, e.din);
      check("R4", {3'b0, wrap_o}, {3'b0, e.wrap}, e.din);
      check("R5", {3'b0, invalid_o}, {3'b0, e.bad}, e.din);
      check("R6", {3'b0, (digit_o <= 4'd9)}, 4'd1, e.din);
      check("R8", {3'b0, (wrap_o & invalid_o)}, 4'd0, e.din);
    end
  end

  initial begin
    rst_n   = 1'b0;
    digit_i = 4'd0;
    repeat (3) @(posedge clk);
    #2;
    // Behaviour while the bench is still in reset: zero steps to one.
    check("R1", digit_o, 4'd1, 4'd0);
    check("R4", {3'b0, wrap_o}, 4'd0, 4'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // Ascending sweep of all sixteen codes.
    for (int i = 0; i < 16; i++) drive(4'(i));
    // Descending sweep.
    for (int i = 15; i >= 0; i--) drive(4'(i));
    // Stride-7 order, so each neighbour pair differs.
    for (int i = 0; i < 16; i++) drive(4'((i * 7) % 16));
    // Boundary pairs around the top and the illegal region.
    drive(4'd8); drive(4'd9); drive(4'd10); drive(4'd9); drive(4'd15); drive(4'd0);

    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);

    // R7: change input mid-cycle and observe without waiting for an edge.
    @(posedge clk);
    #2;
    digit_i = 4'd3;
    #1;
    check("R7", digit_o, 4'd4, 4'd3);
    digit_i = 4'd9;
    #1;
    check("R7", digit_o, 4'd0, 4'd9);
    check("R7", {3'b0, wrap_o}, 4'd1, 4'd9);
    digit_i = 4'd12;
    #1;
    check("R7", {3'b0, invalid_o}, 4'd1, 4'd12);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule